// File: doc/BRIEF.md
# DRAM Bank Timing Tracker with Activation Window

This block keeps the timing bookkeeping for every bank of one DRAM rank. Each bank remembers the row it has open, or none, and three future cycle stamps: the first cycle a column command may go to it, the first cycle it may be closed, and the first cycle it may be opened again. The rank side adds two limits on activations: a minimum gap between consecutive opens, which is longer when both opens land in the same bank group, and a cap on how many opens may fall inside any window of T_XAW cycles.

A scheduler feeds the block one command per cycle: an opcode, a bank and a row. It also feeds a free-running cycle count. It reads back per-bank readiness flags, the open-row state, a per-bank flag saying the row has had its maximum number of accesses and must be closed, the rank-level window flag and the number of open banks. The block records every command it is given. The scheduler decides whether a command should be issued; the block only reports when it may be.

Top module: `dbank_tracker`

## Requirements
- R1: After reset every bank is closed (open row all ones), no bank requests a close, the open-bank count is 0, the window flag is 1, every column and close flag is 0 and every open flag is 1.
- R2: Opcode 1 (open) to bank b with row r, r not all ones, at cycle t makes b open with row r, and its column flag stays 0 until the cycle count reaches t+T_RCD.
- R3: After an open at cycle t the close flag of that bank stays 0 until the cycle count reaches t+T_RAS.
- R4: Opcode 2 (read) at t on an open bank raises its close stamp to the larger of its current value and t+T_RTP. Opcode 3 (write) raises it to the larger of the current value and t+T_BURST+T_WR. Column opcodes to a closed bank change nothing.
- R5: Opcode 4 (close) at t on an open bank makes it closed, and its open flag stays 0 until the cycle count reaches t+T_RP. A close to a closed bank changes nothing.
- R6: Each bank counts column commands since it was opened, saturating at MAX_ACC. The close-request flag is 1 exactly while the bank is open with a count of MAX_ACC. An open clears the count.
- R7: Bank group is the bank index divided by BANKS_PER_GRP. After an open at t, no bank's open flag is 1 before t+T_RRD, nor, for banks of the same group, before t+T_RRD_L.
- R8: The window flag is 0 exactly when ACT_LIMIT opens have been recorded and the oldest of the most recent ACT_LIMIT opens is fewer than T_XAW cycles old. Every open flag follows it.
- R9: The open-bank count always equals the number of open banks.
- R10: An open carrying the all-ones row is ignored. It changes no bank, no count and no activation history.
- R11: Opcodes 0, 5, 6 and 7 are no-ops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| now_i | input | TIME_W | Current cycle count |
| cmd_i | input | 3 | Opcode: 0 none, 1 open, 2 read, 3 write, 4 close |
| bank_i | input | BANK_W | Target bank |
| row_i | input | ROW_W | Row for an open |
| row_open_o | output | NUM_BANKS | Bank has an open row |
| open_row_o | output | NUM_BANKS*ROW_W | Open row per bank, all ones when closed |
| col_ok_o | output | NUM_BANKS | Column command allowed now |
| pre_ok_o | output | NUM_BANKS | Close allowed now |
| act_ok_o | output | NUM_BANKS | Open allowed now (bank, spacing and window) |
| close_req_o | output | NUM_BANKS | Row reached its access limit |
| xaw_ok_o | output | 1 | Activation window permits another open |
| active_cnt_o | output | CNT_W | Number of open banks |

## Verification
The hardest state to reach is a full activation window whose oldest entry is just inside T_XAW. It has to coincide with open flags that are held back by spacing, and with rows that have hit their access limit. Random stimulus alone seldom keeps enough banks cycling to get there. The bench therefore mostly issues commands its own model judges legal, choosing at once whichever bank is ready, so opens arrive in bursts that fill the window. It mixes in arbitrary opcodes, all-ones rows and commands to closed banks to reach the ignore cases.

// File: rtl/dbank_pkg.sv
package dbank_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;
endpackage

// File: rtl/dbank_slot.sv
module dbank_slot
  import dbank_pkg::*;
#(
  parameter int ROW_W   = 8,
  parameter int TIME_W  = 32,
  parameter int T_RCD   = 3,
  parameter int T_RAS   = 8,
  parameter int T_RP    = 3,
  parameter int T_RTP   = 2,
  parameter int T_WR    = 4,
  parameter int T_BURST = 2,
  parameter int MAX_ACC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] now_i,
  input  logic              sel_i,
  input  cmd_e              cmd_i,
  input  logic [ROW_W-1:0]  row_i,
  output logic              open_o,
  output logic [ROW_W-1:0]  row_o,
  output logic              col_ok_o,
  output logic              pre_ok_o,
  output logic              act_ok_o,
  output logic              close_o
);
  localparam int ACC_W = $clog2(MAX_ACC + 1);
  localparam logic [TIME_W-1:0] D_RCD = TIME_W'(T_RCD);
  localparam logic [TIME_W-1:0] D_RAS = TIME_W'(T_RAS);
  localparam logic [TIME_W-1:0] D_RP  = TIME_W'(T_RP);
  localparam logic [TIME_W-1:0] D_RTP = TIME_W'(T_RTP);
  localparam logic [TIME_W-1:0] D_WRE = TIME_W'(T_BURST + T_WR);
  localparam logic [ACC_W-1:0]  ACC_MAX = ACC_W'(MAX_ACC);
  localparam logic [ROW_W-1:0]  NO_ROW = '1;

  logic [ROW_W-1:0]  row_q, row_n;
  logic [TIME_W-1:0] col_q, col_n, pre_q, pre_n, act_q, act_n;
  logic [ACC_W-1:0]  acc_q, acc_n;
  logic              upd;

  function automatic logic [TIME_W-1:0] later(input logic [TIME_W-1:0] a,
                                              input logic [TIME_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  assign open_o = (row_q != NO_ROW);
  assign upd    = sel_i && (cmd_i != CMD_NOP);

  always_comb begin
    row_n = row_q;
    col_n = col_q;
    pre_n = pre_q;
    act_n = act_q;
    acc_n = acc_q;
    unique case (cmd_i)
      CMD_ACT: if (row_i != NO_ROW) begin
        row_n = row_i;
        col_n = now_i + D_RCD;
        pre_n = later(pre_q, now_i + D_RAS);
        acc_n = '0;
      end
      CMD_RD: if (open_o) begin
        pre_n = later(pre_q, now_i + D_RTP);
        if (acc_q != ACC_MAX) acc_n = acc_q + 1'b1;
      end
      CMD_WR: if (open_o) begin
        pre_n = later(pre_q, now_i + D_WRE);
        if (acc_q != ACC_MAX) acc_n = acc_q + 1'b1;
      end
      CMD_PRE: if (open_o) begin
        row_n = NO_ROW;
        act_n = now_i + D_RP;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= NO_ROW;
      col_q <= '0;
      pre_q <= '0;
      act_q <= '0;
      acc_q <= '0;
    end else if (upd) begin
      row_q <= row_n;
      col_q <= col_n;
      pre_q <= pre_n;
      act_q <= act_n;
      acc_q <= acc_n;
    end
  end

  assign row_o    = row_q;
  assign col_ok_o = open_o && (now_i >= col_q);
  assign pre_ok_o = open_o && (now_i >= pre_q);
  assign act_ok_o = !open_o && (now_i >= act_q);
  assign close_o  = open_o && (acc_q == ACC_MAX);

  // R6
  acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q <= ACC_MAX);

  // R2
  act_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && cmd_i == CMD_ACT && row_i != NO_ROW) |=>
      (open_o && col_q == $past(now_i) + D_RCD));

  // R4
  rd_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && cmd_i == CMD_RD && open_o) |=>
      (pre_q >= $past(now_i) + D_RTP && pre_q >= $past(pre_q)));

  // R5
  pre_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && cmd_i == CMD_PRE && open_o) |=> (!open_o && !col_ok_o));
endmodule

// File: rtl/dbank_act_window.sv
module dbank_act_window #(
  parameter int NUM_BANKS     = 8,
  parameter int BANKS_PER_GRP = 2,
  parameter int TIME_W        = 32,
  parameter int T_RRD         = 2,
  parameter int T_RRD_L       = 4,
  parameter int T_XAW         = 16,
  parameter int ACT_LIMIT     = 4,
  localparam int BANK_W  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int NUM_GRP = NUM_BANKS / BANKS_PER_GRP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] now_i,
  input  logic              fire_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic              xaw_ok_o,
  output logic [NUM_GRP-1:0] grp_ok_o
);
  localparam int GRP_SHIFT = $clog2(BANKS_PER_GRP);
  localparam int GRP_W  = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;
  localparam int PTR_W  = (ACT_LIMIT > 1) ? $clog2(ACT_LIMIT) : 1;
  localparam int FILL_W = $clog2(ACT_LIMIT + 1);
  localparam logic [TIME_W-1:0] D_RRD  = TIME_W'(T_RRD);
  localparam logic [TIME_W-1:0] D_RRDL = TIME_W'(T_RRD_L);
  localparam logic [TIME_W-1:0] D_XAW  = TIME_W'(T_XAW);
  localparam logic [FILL_W-1:0] FULL   = FILL_W'(ACT_LIMIT);
  localparam logic [PTR_W-1:0]  LAST   = PTR_W'(ACT_LIMIT - 1);

  logic [TIME_W-1:0] hist_q [ACT_LIMIT];
  logic [PTR_W-1:0]  wp_q, wp_n;
  logic [FILL_W-1:0] fill_q, fill_n;
  logic [TIME_W-1:0] last_t_q;
  logic [GRP_W-1:0]  last_g_q, grp_in;
  logic              has_q;

  assign grp_in = GRP_W'(bank_i >> GRP_SHIFT);

  always_comb begin
    wp_n   = (wp_q == LAST) ? '0 : wp_q + 1'b1;
    fill_n = (fill_q == FULL) ? fill_q : fill_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ACT_LIMIT; i++) hist_q[i] <= '0;
      wp_q     <= '0;
      fill_q   <= '0;
      last_t_q <= '0;
      last_g_q <= '0;
      has_q    <= 1'b0;
    end else if (fire_i) begin
      hist_q[wp_q] <= now_i;
      wp_q     <= wp_n;
      fill_q   <= fill_n;
      last_t_q <= now_i;
      last_g_q <= grp_in;
      has_q    <= 1'b1;
    end
  end

  assign xaw_ok_o = (fill_q != FULL) || ((now_i - hist_q[wp_q]) >= D_XAW);

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic [TIME_W-1:0] gap;
    assign gap = (last_g_q == GRP_W'(g)) ? D_RRDL : D_RRD;
    assign grp_ok_o[g] = !has_q || ((now_i - last_t_q) >= gap);
  end

  // R8
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FULL);

  // R7
  spacing_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |=> (has_q && last_t_q == $past(now_i)));
endmodule

// File: rtl/dbank_tracker.sv
module dbank_tracker
  import dbank_pkg::*;
#(
  parameter int NUM_BANKS     = 8,
  parameter int BANKS_PER_GRP = 2,
  parameter int ROW_W         = 8,
  parameter int TIME_W        = 32,
  parameter int T_RCD         = 3,
  parameter int T_RAS         = 8,
  parameter int T_RP          = 3,
  parameter int T_RTP         = 2,
  parameter int T_WR          = 4,
  parameter int T_BURST       = 2,
  parameter int T_RRD         = 2,
  parameter int T_RRD_L       = 4,
  parameter int T_XAW         = 16,
  parameter int ACT_LIMIT     = 4,
  parameter int MAX_ACC       = 4,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int CNT_W  = $clog2(NUM_BANKS + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [TIME_W-1:0]          now_i,
  input  logic [2:0]                 cmd_i,
  input  logic [BANK_W-1:0]          bank_i,
  input  logic [ROW_W-1:0]           row_i,
  output logic [NUM_BANKS-1:0]       row_open_o,
  output logic [NUM_BANKS*ROW_W-1:0] open_row_o,
  output logic [NUM_BANKS-1:0]       col_ok_o,
  output logic [NUM_BANKS-1:0]       pre_ok_o,
  output logic [NUM_BANKS-1:0]       act_ok_o,
  output logic [NUM_BANKS-1:0]       close_req_o,
  output logic                       xaw_ok_o,
  output logic [CNT_W-1:0]           active_cnt_o
);
  localparam int NUM_GRP = NUM_BANKS / BANKS_PER_GRP;
  localparam logic [ROW_W-1:0] NO_ROW = '1;

  cmd_e                 cmd;
  logic [NUM_BANKS-1:0] bank_free;
  logic [NUM_GRP-1:0]   grp_ok;
  logic                 act_fire, opens, closes;
  logic [CNT_W-1:0]     cnt_q, cnt_n;

  assign cmd      = cmd_e'(cmd_i);
  assign act_fire = (cmd == CMD_ACT) && (row_i != NO_ROW);
  assign opens    = act_fire && !row_open_o[bank_i];
  assign closes   = (cmd == CMD_PRE) && row_open_o[bank_i];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    dbank_slot #(
      .ROW_W(ROW_W), .TIME_W(TIME_W), .T_RCD(T_RCD), .T_RAS(T_RAS),
      .T_RP(T_RP), .T_RTP(T_RTP), .T_WR(T_WR), .T_BURST(T_BURST),
      .MAX_ACC(MAX_ACC)
    ) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .now_i    (now_i),
      .sel_i    (bank_i == BANK_W'(b)),
      .cmd_i    (cmd),
      .row_i    (row_i),
      .open_o   (row_open_o[b]),
      .row_o    (open_row_o[b*ROW_W +: ROW_W]),
      .col_ok_o (col_ok_o[b]),
      .pre_ok_o (pre_ok_o[b]),
      .act_ok_o (bank_free[b]),
      .close_o  (close_req_o[b])
    );
    assign act_ok_o[b] = bank_free[b] && xaw_ok_o && grp_ok[b / BANKS_PER_GRP];
  end

  dbank_act_window #(
    .NUM_BANKS(NUM_BANKS), .BANKS_PER_GRP(BANKS_PER_GRP), .TIME_W(TIME_W),
    .T_RRD(T_RRD), .T_RRD_L(T_RRD_L), .T_XAW(T_XAW), .ACT_LIMIT(ACT_LIMIT)
  ) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .now_i    (now_i),
    .fire_i   (act_fire),
    .bank_i   (bank_i),
    .xaw_ok_o (xaw_ok_o),
    .grp_ok_o (grp_ok)
  );

  always_comb begin
    cnt_n = cnt_q;
    if (opens && !closes) cnt_n = cnt_q + 1'b1;
    else if (closes && !opens) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (opens || closes) cnt_q <= cnt_n;
  end

  assign active_cnt_o = cnt_q;

  // R9
  active_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_cnt_o == CNT_W'($countones(row_open_o)));

  // R10
  bad_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ACT && row_i == NO_ROW) |=> $stable(row_open_o));
endmodule

// File: tb/dbank_tracker_tb.sv
`timescale 1ns/100ps
module dbank_tracker_tb;
  localparam int NB = 8, BPG = 2, RW = 8, TW = 32;
  localparam int RCD = 3, RAS = 8, RP = 3, RTP = 2, TWR = 4, BST = 2;
  localparam int RRD = 2, RRDL = 4, XAW = 16, LIM = 4, MAXA = 4;
  localparam int NOROW = 255;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [TW-1:0] now_i = '0;
  logic [2:0] cmd_i = '0;
  logic [2:0] bank_i = '0;
  logic [RW-1:0] row_i = '0;
  logic [NB-1:0] row_open_o, col_ok_o, pre_ok_o, act_ok_o, close_req_o;
  logic [NB*RW-1:0] open_row_o;
  logic xaw_ok_o;
  logic [3:0] active_cnt_o;

  dbank_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .now_i(now_i), .cmd_i(cmd_i), .bank_i(bank_i),
    .row_i(row_i), .row_open_o(row_open_o), .open_row_o(open_row_o),
    .col_ok_o(col_ok_o), .pre_ok_o(pre_ok_o), .act_ok_o(act_ok_o),
    .close_req_o(close_req_o), .xaw_ok_o(xaw_ok_o), .active_cnt_o(active_cnt_o)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  // reference model state
  int m_row [NB];
  int m_col [NB], m_pre [NB], m_act [NB], m_acc [NB];
  int acts [0:8191];
  int n_acts = 0, last_t = 0, last_g = 0, m_cnt = 0;
  bit has_last = 1'b0;
  int now = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0d)", tag, act, exp, now);
    end
  endtask

  function automatic bit m_open(input int b); return m_row[b] != NOROW; endfunction
  function automatic bit m_xaw();
    return (n_acts < LIM) || (now - acts[n_acts-LIM] >= XAW);
  endfunction
  function automatic bit m_grp(input int b);
    int gap;
    gap = ((b / BPG) == last_g) ? RRDL : RRD;
    return !has_last || (now - last_t >= gap);
  endfunction
  function automatic bit m_col_ok(input int b); return m_open(b) && now >= m_col[b]; endfunction
  function automatic bit m_pre_ok(input int b); return m_open(b) && now >= m_pre[b]; endfunction
  function automatic bit m_act_ok(input int b);
    return !m_open(b) && now >= m_act[b] && m_xaw() && m_grp(b);
  endfunction
  function automatic bit m_close(input int b); return m_open(b) && m_acc[b] == MAXA; endfunction
  function automatic int imax(input int a, input int c); return a > c ? a : c; endfunction

  task automatic model_reset();
    for (int b = 0; b < NB; b++) begin
      m_row[b] = NOROW; m_col[b] = 0; m_pre[b] = 0; m_act[b] = 0; m_acc[b] = 0;
    end
    n_acts = 0; has_last = 1'b0; m_cnt = 0;
  endtask

  task automatic model_cmd(input int c, input int b, input int r);
    case (c)
      1: if (r != NOROW) begin
        if (!m_open(b)) m_cnt++;
        m_row[b] = r; m_col[b] = now + RCD; m_pre[b] = imax(m_pre[b], now + RAS);
        m_acc[b] = 0; acts[n_acts] = now; n_acts++;
        last_t = now; last_g = b / BPG; has_last = 1'b1;
      end
      2, 3: if (m_open(b)) begin
        if (m_acc[b] < MAXA) m_acc[b]++;
        m_pre[b] = imax(m_pre[b], now + ((c == 2) ? RTP : BST + TWR));
      end
      4: if (m_open(b)) begin
        m_row[b] = NOROW; m_act[b] = now + RP; m_cnt--;
      end
      default: ;
    endcase
  endtask

  task automatic check_all();
    for (int b = 0; b < NB; b++) begin
      chk($sformatf("R2 R5 open bank%0d", b), int'(row_open_o[b]), int'(m_open(b)));
      chk($sformatf("R2 row bank%0d", b), int'(open_row_o[b*RW +: RW]), m_row[b]);
      chk($sformatf("R2 col_ok bank%0d", b), int'(col_ok_o[b]), int'(m_col_ok(b)));
      chk($sformatf("R3 R4 pre_ok bank%0d", b), int'(pre_ok_o[b]), int'(m_pre_ok(b)));
      chk($sformatf("R5 R7 R8 act_ok bank%0d", b), int'(act_ok_o[b]), int'(m_act_ok(b)));
      chk($sformatf("R6 close_req bank%0d", b), int'(close_req_o[b]), int'(m_close(b)));
    end
    chk("R8 xaw_ok", int'(xaw_ok_o), int'(m_xaw()));
    chk("R9 active_cnt", int'(active_cnt_o), m_cnt);
  endtask

  // one cycle: advance time at negedge, check, then drive and model a command
  task automatic step(input int c, input int b, input int r);
    @(negedge clk);
    now = now + 1;
    now_i = TW'(now);
    #1;
    check_all();
    model_cmd(c, b, r);
    cmd_i = 3'(c); bank_i = 3'(b); row_i = RW'(r);
  endtask

  task automatic pick(output int c, output int b, output int r);
    int p;
    p = int'($urandom % 100);
    b = int'($urandom % NB);
    r = int'($urandom % NOROW);
    c = 0;
    if (p < 12) c = 0;
    else if (p < 27) begin
      c = int'($urandom % 8);
      if ($urandom % 6 == 0) r = NOROW;
    end else begin
      for (int k = 0; k < NB; k++) begin
        int bb;
        bb = (b + k) % NB;
        if (m_open(bb)) begin
          if ((m_close(bb) || $urandom % 5 == 0) && m_pre_ok(bb)) begin c = 4; b = bb; break; end
          if (m_col_ok(bb) && !m_close(bb)) begin c = 2 + int'($urandom % 2); b = bb; break; end
        end else if (m_act_ok(bb)) begin
          c = 1; b = bb; break;
        end
      end
    end
  endtask

  initial begin
    int c, b, r;
    void'($urandom(32'd4321));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 active_cnt", int'(active_cnt_o), 0);
    chk("R1 row_open", int'(row_open_o), 0);
    chk("R1 act_ok", int'(act_ok_o), 255);
    chk("R1 col_ok", int'(col_ok_o), 0);
    chk("R1 close_req", int'(close_req_o), 0);
    chk("R1 xaw_ok", int'(xaw_ok_o), 1);

    // R10: open with all-ones row ignored
    step(1, 2, NOROW);
    step(0, 0, 0);
    chk("R10 bank2 stays closed", int'(row_open_o[2]), 0);
    chk("R10 count unchanged", int'(active_cnt_o), 0);
    // R11: opcodes 5..7 ignored
    step(5, 3, 7);
    step(6, 3, 7);
    step(7, 3, 7);
    step(0, 0, 0);
    chk("R11 bank3 stays closed", int'(row_open_o[3]), 0);
    chk("R11 count unchanged", int'(active_cnt_o), 0);
    // R2/R3 directed: open bank 0 row 9, watch col_ok edge
    step(1, 0, 9);
    for (int i = 1; i <= RAS; i++) step(0, 0, 0);
    chk("R3 pre_ok after RAS", int'(pre_ok_o[0]), 1);
    // R6 directed: MAX_ACC reads then close request
    for (int i = 0; i < MAXA + 1; i++) step(2, 0, 0);
    step(0, 0, 0);
    chk("R6 close_req set", int'(close_req_o[0]), 1);
    step(4, 0, 0);
    step(0, 0, 0);
    chk("R5 closed", int'(row_open_o[0]), 0);
    // R8 directed: burst of opens on distinct groups fills window
    step(1, 0, 1); step(0, 0, 0); step(1, 2, 1); step(0, 0, 0);
    step(1, 4, 1); step(0, 0, 0); step(1, 6, 1); step(0, 0, 0);
    chk("R8 window full", int'(xaw_ok_o), 0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      pick(c, b, r);
      step(c, b, r);
    end
    step(0, 0, 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule